// File: doc/BRIEF.md
# Level Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt lines into one combined interrupt request for a processor. Every clock cycle, each input line is copied into its own pending bit. A separate enable mask selects which pending bits count as active. The single output is raised while any active bit exists.

Software reaches the block over a simple 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe with combinational read data. Software can read the active bits as a vector, or read how many of them are set. It can set enable bits, clear enable bits, or wipe the enable mask and the pending state with a single command.

Pending bits are not latches that software clears. They follow the input levels, so a source must drop its line to retire its request. After a wipe, any line that is still high sets its pending bit again on the next cycle.

Top module: `level_irq_aggregator`

## Requirements
- R1: After reset, both read registers return zero and `irq_o` is low.
- R2: Each pending bit takes the level of its input line at every rising clock edge. A line that drops clears its bit on the next edge.
- R3: A read of offset 0x04 returns pending AND enable, not the raw pending vector.
- R4: A read of offset 0x00 returns the number of set bits in pending AND enable, from 0 to 32, zero-extended to 32 bits.
- R5: A write to offset 0x10 ORs the write data into the enable mask.
- R6: A write to offset 0x0C clears every enable bit where the write data holds a 1, and leaves the other enable bits unchanged.
- R7: Any write to offset 0x08 clears the enable mask and the pending vector, whatever the data. Inputs still high set their pending bits again on the following edge.
- R8: `irq_o` is a register. It is high exactly when pending AND enable was nonzero after the previous clock edge, so it lags the state that causes it by one cycle.
- R9: A read of any offset other than 0x00 or 0x04 returns zero. This covers the write-only offsets, the reserved offsets up to 0x20, misaligned offsets and offsets outside the window.
- R10: A write to 0x00, 0x04, a reserved offset or a misaligned offset leaves the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive interrupt lines |
| addr_i | input | 6 | Byte offset of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the same cycle as `re_i`; zero when `re_i` is low |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following:
- the enable-mask update rules for set, clear and wipe writes;
- that the population count agrees with an independent count of the active vector;
- that `irq_o` is low two cycles after a wipe;
- that reads of unmapped offsets return zero.

Some behaviours can only be shown by the bench's scenarios. These are:
- that pending bits track the input levels;
- the exact one-cycle lag of `irq_o`, both rising and falling;
- that writes to read-only or reserved offsets leave the mask untouched;
- that lines still high re-arm after a wipe.

The bench walks the enable mask one bit at a time and sweeps a set of computed input patterns to do this.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int unsigned LIA_NUM_IRQ = 32;
  localparam int unsigned LIA_DATA_W  = 32;
  localparam int unsigned LIA_ADDR_W  = 6;

  // register byte offsets
  localparam int unsigned OFF_COUNT  = 'h00;
  localparam int unsigned OFF_ACTIVE = 'h04;
  localparam int unsigned OFF_WIPE   = 'h08;
  localparam int unsigned OFF_MASK_C = 'h0C;
  localparam int unsigned OFF_MASK_S = 'h10;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic wipe;
    logic rd_count;
    logic rd_active;
  } lia_strobe_t;
endpackage

// File: rtl/lia_decode.sv
module lia_decode
  import lia_pkg::*;
#(
  parameter int unsigned ADDR_W = LIA_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output lia_strobe_t       strb_o
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_ACTIVE = ADDR_W'(OFF_ACTIVE);
  localparam logic [ADDR_W-1:0] A_WIPE   = ADDR_W'(OFF_WIPE);
  localparam logic [ADDR_W-1:0] A_MASK_C = ADDR_W'(OFF_MASK_C);
  localparam logic [ADDR_W-1:0] A_MASK_S = ADDR_W'(OFF_MASK_S);

  always_comb begin
    strb_o           = '0;
    strb_o.set_en    = we_i && (addr_i == A_MASK_S);
    strb_o.clr_en    = we_i && (addr_i == A_MASK_C);
    strb_o.wipe      = we_i && (addr_i == A_WIPE);
    strb_o.rd_count  = re_i && (addr_i == A_COUNT);
    strb_o.rd_active = re_i && (addr_i == A_ACTIVE);
  end

  // R10
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_COUNT || addr_i == A_ACTIVE))
      |-> !(strb_o.set_en || strb_o.clr_en || strb_o.wipe));
endmodule

// File: rtl/lia_popcount.sv
module lia_popcount #(
  parameter int unsigned N     = 32,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     vec_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned LEAVES = 1 << $clog2(N);

  logic [CNT_W-1:0] node [1:2*LEAVES-1];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < N) begin : g_used
      assign node[LEAVES+g] = CNT_W'(vec_i[g]);
    end else begin : g_pad
      assign node[LEAVES+g] = '0;
    end
  end

  for (genvar j = 1; j < LEAVES; j++) begin : g_sum
    assign node[j] = node[2*j] + node[2*j+1];
  end

  assign count_o = node[1];

  // R4
  popcount_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == CNT_W'($countones(vec_i)));
endmodule

// File: rtl/lia_irq_state.sv
module lia_irq_state #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic         wipe_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] active_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // inputs are re-sampled every cycle; a wipe clears only this cycle
      pend_q <= wipe_i ? '0 : irq_i;
      if (wipe_i)        en_q <= '0;
      else if (clr_en_i) en_q <= en_q & ~wdata_i;
      else if (set_en_i) en_q <= en_q | wdata_i;
    end
  end

  assign active_o = pend_q & en_q;

  // R5
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((en_q & $past(wdata_i)) == '0));

  // R6
  en_clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  // R7
  wipe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> (en_q == '0 && pend_q == '0));
endmodule

// File: rtl/level_irq_aggregator.sv
module level_irq_aggregator
  import lia_pkg::*;
#(
  parameter int unsigned NUM_IRQ = LIA_NUM_IRQ,
  parameter int unsigned DATA_W  = LIA_DATA_W,
  parameter int unsigned ADDR_W  = LIA_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(NUM_IRQ + 1);

  lia_strobe_t        strb;
  logic [NUM_IRQ-1:0] active;
  logic [CNT_W-1:0]   count;
  logic               irq_q;

  lia_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .re_i   (re_i),
    .strb_o (strb)
  );

  lia_irq_state #(.N(NUM_IRQ)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .set_en_i (strb.set_en),
    .clr_en_i (strb.clr_en),
    .wipe_i   (strb.wipe),
    .wdata_i  (wdata_i[NUM_IRQ-1:0]),
    .active_o (active)
  );

  lia_popcount #(.N(NUM_IRQ), .CNT_W(CNT_W)) u_popcount (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vec_i   (active),
    .count_o (count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |active;
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (strb.rd_count)       rdata_o = DATA_W'(count);
    else if (strb.rd_active) rdata_o = DATA_W'(active);
  end

  // R8
  irq_low_after_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.wipe |-> ##2 !irq_o);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i != ADDR_W'(OFF_COUNT) && addr_i != ADDR_W'(OFF_ACTIVE))
      |-> rdata_o == '0);
endmodule

// File: tb/tb_level_irq_aggregator.sv
module tb_level_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_en = '0;

  always #4 clk = ~clk;

  level_irq_aggregator dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a; re = 1'b1;
    #1;
    v = rdata;
    re = 1'b0;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
  endtask

  // reads active vector and count, then irq_o one edge later
  task automatic chk_state(input string req);
    logic [31:0] v;
    rd(6'h04, v);
    check({req, " active"}, v, irq & m_en);
    rd(6'h00, v);
    check({req, " count"}, v, 32'($countones(irq & m_en)));
    @(negedge clk);
    check({req, " irq_o"}, {31'b0, irq_o}, {31'b0, |(irq & m_en)});
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    logic [5:0]  ro_addr [6];
    logic [5:0]  nr_addr [8];
    ro_addr = '{6'h00, 6'h04, 6'h14, 6'h18, 6'h20, 6'h11};
    nr_addr = '{6'h08, 6'h0C, 6'h10, 6'h14, 6'h20, 6'h23, 6'h02, 6'h3C};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_state("R1");

    // R3: lines high, mask empty
    set_irq(32'hFFFF_FFFF);
    chk_state("R3");

    // R5 / R4: walk the enable mask upward
    for (int i = 0; i < 32; i++) begin
      wr(6'h10, 32'h1 << i);
      m_en |= 32'h1 << i;
      chk_state("R5");
    end

    // R6
    wr(6'h0C, 32'h5555_5555);
    m_en &= ~32'h5555_5555;
    chk_state("R6");
    wr(6'h0C, 32'h0);
    chk_state("R6 zero data");

    // R2 / R3 / R4: computed input patterns
    pat = 32'h1357_9BDF;
    for (int k = 0; k < 16; k++) begin
      pat = (pat << 5) ^ (pat >> 3) ^ (32'h9E37_79B9 * (k + 1));
      set_irq(pat);
      chk_state("R2");
    end
    wr(6'h10, 32'hFFFF_FFFF);
    m_en = 32'hFFFF_FFFF;
    set_irq(32'hFFFF_FFFF);
    chk_state("R4 full");
    set_irq(32'h0);
    chk_state("R2 all low");
    set_irq(32'h8000_0001);
    chk_state("R4 ends");

    // R10: writes to read-only, reserved and misaligned offsets
    set_irq(32'hA5A5_A5A5);
    foreach (ro_addr[i]) begin
      wr(ro_addr[i], 32'hFFFF_FFFF);
      wr(ro_addr[i], 32'h0);
      chk_state("R10");
    end

    // R9: reads of offsets outside the read registers
    foreach (nr_addr[i]) begin
      rd(nr_addr[i], v);
      check("R9", v, 32'h0);
    end

    // R8: exact lag of irq_o
    set_irq(32'h0);
    @(negedge clk);
    check("R8 idle", {31'b0, irq_o}, 32'h0);
    irq = 32'h1;
    @(negedge clk);
    check("R8 lag", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R8 rise", {31'b0, irq_o}, 32'h1);
    wr(6'h0C, 32'h1);
    m_en &= ~32'h1;
    check("R8 hold", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R8 fall", {31'b0, irq_o}, 32'h0);

    // R7: wipe with arbitrary data while lines stay high
    wr(6'h10, 32'hFFFF_FFFF);
    m_en = 32'hFFFF_FFFF;
    set_irq(32'hFFFF_FFFF);
    @(negedge clk);
    wr(6'h08, 32'h1234_5678);
    m_en = '0;
    chk_state("R7 wipe");
    wr(6'h10, 32'hF0F0_F0F0);
    m_en = 32'hF0F0_F0F0;
    chk_state("R7 rearm");
    wr(6'h08, 32'h0);
    m_en = '0;
    chk_state("R7 zero data");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule